// File: doc/BRIEF.md
# Programmable Glitch-Free Clock Divider

This block is one slice of a microcontroller-style clock tree. A select field chooses one of eight source clocks, and the block divides the chosen clock by a programmable 16-bit ratio. The output has close to 50% duty, and it is a register of the system clock, so it is resynchronized to that domain by construction. Every source clock is first brought into the system clock domain through a two-flop synchronizer. Its rising edges then serve as count enables. For this reason each source must be slower than half the system clock.

Changes of source or ratio never produce a short pulse.

- **Source change:** a handshake holds the output low at a safe edge of the old source. It then lets two edges of the new source pass before the output is released.
- **Ratio change:** a new ratio is taken only at the terminal count, so the period in progress always completes.

A one-cycle terminal-count strobe marks each output period. Feeding this strobe into a source input of a second slice chains the two into a divide of up to 32 bits. An enable input stops the counter and holds the output low.

Top module: `clkdiv_slice`

## Requirements
- R1: After reset, clk_out and tc_pulse are 0.
- R2: With div_val = N (N >= 1) the output period is R = N+1 periods of the selected source. The output is high for floor(R/2) source periods and low for the remaining R - floor(R/2).
- R3: div_val = 0 behaves exactly as div_val = 1, which is a divide by 2.
- R4: src_sel = k selects src_clk[k] for k in 0..7.
- R5: On a source change, any high phase in progress completes in full and the output then stays low. It stays low for at least two periods of the new source. The first pulse after the change is a full high phase of the new source.
- R6: A new div_val takes effect only at the terminal count. The period in progress completes with the old ratio, and the next period uses the new one.
- R7: tc_pulse is high for exactly one clk_sys cycle per output period, in the cycle in which clk_out rises at a wrap.
- R8: While div_en is 0, clk_out is 0 from the next clk_sys cycle on and tc_pulse stays 0. After re-enable, the output restarts with a full high phase.
- R9: When tc_pulse of one slice drives a source input of a second slice, the second slice's output period is the product of the two ratios times the first slice's source period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_clk | input | 8 | Source clocks, sampled in the clk_sys domain |
| src_sel | input | 3 | Index of the selected source |
| div_val | input | 16 | Ratio value N; the divide is N+1, and 0 is clamped to 1 |
| div_en | input | 1 | Counter enable; the output is held low when this is 0 |
| clk_out | output | 1 | Divided clock, registered on clk_sys |
| tc_pulse | output | 1 | One-cycle terminal-count strobe for chaining |

## Verification
A rising edge of a source reaches clk_out on the third clk_sys edge: two synchronizer flops, then the output register. Because this delay is the same for every edge, the bench measures high and low durations as counts of clk_sys cycles between level changes and compares them with floor(R/2)·P and (R - floor(R/2))·P. The bench generates every source with an exact period of P clk_sys cycles and samples 2 ns after each rising edge. The strobe is registered in the same cycle as the output's rise, so it is counted over the window that runs from one rise to the next. For source changes, only a lower bound of two new source periods can be stated for the low gap, and the checks use that bound. A disable shows at the output after one clk_sys edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    SW_RUN   = 2'd0,
    SW_DRAIN = 2'd1,
    SW_WAIT1 = 2'd2,
    SW_WAIT2 = 2'd3
  } sw_state_e;
endpackage

// File: rtl/clkdiv_src_sync.sv
module clkdiv_src_sync #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  output logic [NSRC-1:0] src_rise
);
  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_lane
      logic meta_q, sync_q, prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b0;
          sync_q <= 1'b0;
          prev_q <= 1'b0;
        end else begin
          meta_q <= src_in[gi];
          sync_q <= meta_q;
          prev_q <= sync_q;
        end
      end
      assign src_rise[gi] = sync_q & ~prev_q;
    end
  endgenerate
endmodule

// File: rtl/clkdiv_switch.sv
module clkdiv_switch
  import clkdiv_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_rise,
  input  logic [SELW-1:0] req_sel,
  input  logic            safe_stop,
  input  logic            div_idle,
  output logic            sel_tick,
  output logic            run
);
  sw_state_e      st_q, st_n;
  logic [SELW-1:0] cur_q, cur_n;

  assign sel_tick = src_rise[cur_q];
  assign run      = (st_q == SW_RUN) || (st_q == SW_DRAIN);

  always_comb begin
    st_n  = st_q;
    cur_n = cur_q;
    unique case (st_q)
      SW_RUN: begin
        if (req_sel != cur_q) st_n = SW_DRAIN;
      end
      SW_DRAIN: begin
        if (div_idle || (sel_tick && safe_stop)) begin
          cur_n = req_sel;
          st_n  = SW_WAIT1;
        end
      end
      SW_WAIT1: begin
        if (sel_tick) st_n = SW_WAIT2;
      end
      SW_WAIT2: begin
        if (sel_tick) st_n = SW_RUN;
      end
      default: st_n = SW_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SW_RUN;
      cur_q <= '0;
    end else begin
      st_q  <= st_n;
      cur_q <= cur_n;
    end
  end

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SW_DRAIN) |=> $stable(cur_q));

  // R5
  wait_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SW_WAIT1) |=> (st_q == SW_WAIT1 || st_q == SW_WAIT2));
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          en,
  input  logic [DW-1:0] div_val,
  output logic          out_clk,
  output logic          tc,
  output logic          safe_stop,
  output logic          idle
);
  logic [DW-1:0] cnt_q, cnt_n, term_q, term_n, term_new;
  logic          out_q, out_n, tc_q, tc_n, idle_q, idle_n;
  logic [DW:0]   half, cnt_inc;
  logic          active, at_term;

  assign active   = run & en;
  assign term_new = (div_val == '0) ? {{(DW-1){1'b0}}, 1'b1} : div_val;
  assign half     = ({1'b0, term_q} + {{DW{1'b0}}, 1'b1}) >> 1;
  assign cnt_inc  = {1'b0, cnt_q} + {{DW{1'b0}}, 1'b1};
  assign at_term  = (cnt_q == term_q);

  assign safe_stop = active & tick & ~idle_q & ~at_term & (cnt_inc >= half);

  always_comb begin
    cnt_n  = cnt_q;
    term_n = term_q;
    out_n  = out_q;
    idle_n = idle_q;
    tc_n   = 1'b0;
    if (!active) begin
      cnt_n  = '0;
      out_n  = 1'b0;
      idle_n = 1'b1;
    end else if (tick) begin
      if (idle_q) begin
        cnt_n  = '0;
        term_n = term_new;
        out_n  = 1'b1;
        idle_n = 1'b0;
      end else if (at_term) begin
        cnt_n  = '0;
        term_n = term_new;
        out_n  = 1'b1;
        tc_n   = 1'b1;
      end else begin
        cnt_n = cnt_inc[DW-1:0];
        out_n = (cnt_inc < half);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      term_q <= {{(DW-1){1'b0}}, 1'b1};
      out_q  <= 1'b0;
      tc_q   <= 1'b0;
      idle_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_n;
      term_q <= term_n;
      out_q  <= out_n;
      tc_q   <= tc_n;
      idle_q <= idle_n;
    end
  end

  assign out_clk = out_q;
  assign tc      = tc_q;
  assign idle    = idle_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term_q);

  // R7
  tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |=> !tc_q);

  // R2
  rise_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> (cnt_q == '0));

  // R8
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && en) |=> (!out_q && !tc_q));

  // R6
  term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !idle_q && !(tick && at_term)) |=> $stable(term_q));
endmodule

// File: rtl/clkdiv_slice.sv
module clkdiv_slice #(
  parameter int NSRC = 8,
  parameter int DW   = 16,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic            clk_sys,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_clk,
  input  logic [SELW-1:0] src_sel,
  input  logic [DW-1:0]   div_val,
  input  logic            div_en,
  output logic            clk_out,
  output logic            tc_pulse
);
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic [NSRC-1:0] rise;
  logic            tick, run, safe_stop, idle;

  clkdiv_src_sync #(.NSRC(NSRC)) u_sync (
    .clk      (clk_sys),
    .rst_n    (rst_s_q),
    .src_in   (src_clk),
    .src_rise (rise)
  );

  clkdiv_switch #(.NSRC(NSRC)) u_sw (
    .clk       (clk_sys),
    .rst_n     (rst_s_q),
    .src_rise  (rise),
    .req_sel   (src_sel),
    .safe_stop (safe_stop),
    .div_idle  (idle),
    .sel_tick  (tick),
    .run       (run)
  );

  clkdiv_core #(.DW(DW)) u_core (
    .clk       (clk_sys),
    .rst_n     (rst_s_q),
    .tick      (tick),
    .run       (run),
    .en        (div_en),
    .div_val   (div_val),
    .out_clk   (clk_out),
    .tc        (tc_pulse),
    .safe_stop (safe_stop),
    .idle      (idle)
  );

  // R5
  run_gate_chk: assert property (@(posedge clk_sys) disable iff (!rst_s_q)
    !run |=> !$rose(clk_out));

  // R7
  tc_with_rise_chk: assert property (@(posedge clk_sys) disable iff (!rst_s_q)
    tc_pulse |-> clk_out);
endmodule

// File: tb/clkdiv_slice_test.sv
module clkdiv_slice_test;
  localparam int LIM = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  src;
  logic [2:0]  sel;
  logic [15:0] dv;
  logic        en;
  logic        co1, tc1, co2, tc2;
  int          ph = 0;
  int          total = 0;
  int          bad = 0;
  int          tc_seen = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  always @(negedge clk) ph <= ph + 1;

  always_comb begin
    for (int i = 0; i < 8; i++) src[i] = ((ph % (4 + 2*i)) < (2 + i));
  end

  clkdiv_slice uut (
    .clk_sys(clk), .rst_n(rst_n), .src_clk(src), .src_sel(sel),
    .div_val(dv), .div_en(en), .clk_out(co1), .tc_pulse(tc1));

  clkdiv_slice uut2 (
    .clk_sys(clk), .rst_n(rst_n), .src_clk({7'b0, tc1}), .src_sel(3'd0),
    .div_val(16'd3), .div_en(1'b1), .clk_out(co2), .tc_pulse(tc2));

  function automatic int per(int s);
    return 4 + 2*s;
  endfunction

  task automatic tick();
    @(posedge clk); #2;
    if (tc1) tc_seen++;
  endtask

  function automatic logic outv(int w);
    return (w != 0) ? co2 : co1;
  endfunction

  task automatic wait_rise(int w);
    int n = 0;
    while (outv(w) !== 1'b0 && n < LIM) begin tick(); n++; end
    while (outv(w) !== 1'b1 && n < LIM) begin tick(); n++; end
  endtask

  task automatic run_len(int w, logic v, output int n);
    n = 0;
    while (outv(w) === v && n < LIM) begin tick(); n++; end
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_ge(string tag, int act, int lo);
    total++;
    if (act < lo) begin
      bad++;
      $display("FAIL %s actual=%0d expected>=%0d", tag, act, lo);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int hi, lo, gap, r, h, p, cnt;
    rst_n = 1'b0; sel = 3'd0; dv = 16'd1; en = 1'b0;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    // R1 reset state
    chk("R1 clk_out after reset", int'(co1), 0);
    chk("R1 tc_pulse after reset", int'(tc1), 0);
    en = 1'b1;

    // R2 R3 R4 R7 sweep of sources and ratios
    for (int s = 0; s < 8; s++) begin
      for (int n = 0; n < 7; n++) begin
        sel = 3'(s); dv = 16'(n);
        wait_rise(0);
        tc_seen = 0;
        run_len(0, 1'b1, hi);
        run_len(0, 1'b0, lo);
        r = (n == 0) ? 2 : n + 1; h = r / 2; p = per(s);
        if (n == 0) begin
          chk("R3 clamp high", hi, p);
          chk("R3 clamp low", lo, p);
        end else begin
          chk("R2 R4 high length", hi, h * p);
          chk("R2 R4 low length", lo, (r - h) * p);
        end
        chk("R7 tc per period", tc_seen, 1);
      end
    end

    // R6 ratio change mid-period
    sel = 3'd2; dv = 16'd4;
    wait_rise(0); wait_rise(0);
    dv = 16'd1;
    run_len(0, 1'b1, hi); run_len(0, 1'b0, lo);
    chk("R6 old high completes", hi, 16);
    chk("R6 old low completes", lo, 24);
    run_len(0, 1'b1, hi); run_len(0, 1'b0, lo);
    chk("R6 new high", hi, 8);
    chk("R6 new low", lo, 8);
    dv = 16'd6;
    run_len(0, 1'b1, hi); run_len(0, 1'b0, lo);
    chk("R6 old high again", hi, 8);
    chk("R6 old low again", lo, 8);
    run_len(0, 1'b1, hi); run_len(0, 1'b0, lo);
    chk("R6 longer high", hi, 24);
    chk("R6 longer low", lo, 32);

    // R5 source change during a high phase
    sel = 3'd5;
    run_len(0, 1'b1, hi); run_len(0, 1'b0, gap);
    chk("R5 high completes", hi, 24);
    chk_ge("R5 low gap", gap, 2 * per(5));
    run_len(0, 1'b1, hi); run_len(0, 1'b0, lo);
    chk("R5 new source high", hi, 3 * per(5));
    chk("R5 new source low", lo, 4 * per(5));

    // R5 source change during a low phase
    run_len(0, 1'b1, hi);
    sel = 3'd1;
    run_len(0, 1'b0, gap);
    chk_ge("R5 low gap from low", gap, 2 * per(1));
    run_len(0, 1'b1, hi); run_len(0, 1'b0, lo);
    chk("R5 high after low switch", hi, 3 * per(1));
    chk("R5 low after low switch", lo, 4 * per(1));

    // R8 enable gating
    wait_rise(0);
    en = 1'b0;
    tc_seen = 0;
    tick();
    chk("R8 output low after disable", int'(co1), 0);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin tick(); if (co1) cnt++; end
    chk("R8 output stays low", cnt, 0);
    chk("R8 no tc while disabled", tc_seen, 0);
    en = 1'b1;
    wait_rise(0);
    run_len(0, 1'b1, hi); run_len(0, 1'b0, lo);
    chk("R8 restart high", hi, 3 * per(1));
    chk("R8 restart low", lo, 4 * per(1));

    // R9 chaining through tc into second slice (ratio 3 then 4)
    sel = 3'd0; dv = 16'd2;
    wait_rise(0); wait_rise(0);
    wait_rise(1); wait_rise(1);
    run_len(1, 1'b1, hi); run_len(1, 1'b0, lo);
    chk("R9 chained high", hi, 24);
    chk("R9 chained low", lo, 24);

    finish_run();
  end
endmodule